// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block produces a periodic tick interrupt from a slow reference. An input strobe, pulsing once per period of a 32768 Hz reference, feeds a power-of-two prescaler; each prescaled strobe decrements a down-counter. When the counter runs out, the block sets a sticky pending flag, drives the interrupt line high and reloads the counter from the programmed tick count, so the interrupt repeats every `reload` prescaled strobes until the timer is stopped.

Software programs it through a small register window: a control word holding a global enable, a tick enable and a 4-bit prescale select, a tick-count (reload) register, a pending register with write-one-to-clear semantics and a read-only view of the live counter. Starting is edge-driven: the timer only starts on a control write that raises the tick enable while the global enable is set and a reload value has been stored.

Top module: `prescaled_tick_timer`

## Requirements
- R1: With select n in control bits [7:4], the counter steps once every 2^n reference strobes. The select takes effect only from control writes with bit 0 set, and the prescaler restarts at zero when the timer starts, so the first step comes on the 2^n-th strobe after the start.
- R2: A write to the reload register (address 1) is stored only if the value is greater than 2; writes of 0, 1 or 2 leave the stored value unchanged.
- R3: The timer starts, loading the live counter with the reload value, only on a control write (address 0) that has bit 0 set, sets tick enable bit 8 while the stored bit 8 is 0, and finds a nonzero reload value. A control write that keeps bit 8 at 1, or that has bit 0 clear, neither starts nor reloads.
- R4: The timer stops, freezing the live counter, on a control write with bit 0 set and bit 8 falling from 1 to 0, or on a control write that clears bit 0 while the stored bit 0 is 1.
- R5: On a step that finds the live counter at 1 or below, pending bit 0 is set, the interrupt output goes high, the counter is reloaded and the timer keeps running; the interrupt repeats every reload-value steps.
- R6: Writing to the pending register (address 2) with bit 0 at 1 clears the pending bit and drops the interrupt; bit 0 at 0 has no effect. An expiry in the same cycle as a clear wins.
- R7: Reading address 3 returns the live counter value, which decrements by one on every step while it is above 1.
- R8: After reset the control, reload and pending registers and the live counter read 0, the interrupt is low and the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refStrobe | input | 1 | One-cycle pulse per reference period |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 2 | Write address: 0 control, 1 reload, 2 pending |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address: 0 control, 1 reload, 2 pending, 3 live count |
| rdData | output | 16 | Read data, combinational from rdAddr |
| tickIrq | output | 1 | Tick interrupt, high while the pending bit is set |

## Verification
The counter is driven with select 0, where each reference strobe is a step, and with select 2, where three strobes must leave the counter untouched and the fourth must move it; the pair tells a dead prescaler from a wrong ratio. Start is tried with the global enable missing, with tick enable already high and with no reload value stored, which separates level from edge start. Stops through each of the two enable bits are followed by strobes that must not move the counter, and a clear issued in the same cycle as an expiry shows which of the two takes priority.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_LIVE = 2'd3;
  // control word field positions (software visible)
  localparam int EN_BIT = 0;
  localparam int SEL_LSB = 4;
  localparam int TICK_BIT = 8;

  typedef struct packed {
    logic load;      // start: copy reload into counter
    logic step;      // prescaled strobe while running
    logic wrReload;  // accepted reload write
    logic clrPend;   // write-one-to-clear of pending bit
  } tickStb_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W = 4,
  parameter int MIN_RELOAD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refStrobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              reloadNonzero,
  output tickStb_t          stb,
  output logic              ctrlEn,
  output logic              ctrlTickEn,
  output logic [SEL_W-1:0]  ctrlSel,
  output logic              running
);
  localparam int PRE_W = (2 ** SEL_W) - 1;

  logic [SEL_W-1:0] activeSel;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic isCtrlWr;
  logic newEn;
  logic newTick;
  logic [SEL_W-1:0] newSel;
  logic startReq;
  logic stopReq;
  logic preHit;

  assign isCtrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign newEn = wrData[EN_BIT];
  assign newTick = wrData[TICK_BIT];
  assign newSel = wrData[SEL_LSB +: SEL_W];

  assign startReq = isCtrlWr && newEn && newTick && !ctrlTickEn && reloadNonzero;
  assign stopReq = isCtrlWr && ((newEn && !newTick && ctrlTickEn) || (!newEn && ctrlEn));

  // low n bits of the divider all ones marks every 2^n-th strobe
  assign preMask = (PRE_W'(1) << activeSel) - PRE_W'(1);
  assign preHit = (preCnt & preMask) == preMask;

  always_comb begin
    stb.load = startReq;
    stb.step = running && !stopReq && refStrobe && preHit;
    stb.wrReload = wrEn && (wrAddr == ADDR_RELOAD) && (wrData > DATA_W'(MIN_RELOAD));
    stb.clrPend = wrEn && (wrAddr == ADDR_PEND) && wrData[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn <= 1'b0;
      ctrlTickEn <= 1'b0;
      ctrlSel <= '0;
      activeSel <= '0;
      running <= 1'b0;
      preCnt <= '0;
    end else begin
      if (isCtrlWr) begin
        ctrlEn <= newEn;
        ctrlTickEn <= newTick;
        ctrlSel <= newSel;
        if (newEn) activeSel <= newSel;
      end
      if (startReq) running <= 1'b1;
      else if (stopReq) running <= 1'b0;
      if (startReq) preCnt <= '0;
      else if (running && refStrobe) preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] reloadVal,
  output logic [DATA_W-1:0] liveCnt,
  output logic              pending
);
  logic expire;

  assign expire = stb.step && (liveCnt <= DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      liveCnt <= '0;
      pending <= 1'b0;
    end else begin
      if (stb.wrReload) reloadVal <= wrData;
      if (stb.load) liveCnt <= reloadVal;
      else if (stb.step) liveCnt <= expire ? reloadVal : liveCnt - DATA_W'(1);
      if (expire) pending <= 1'b1;
      else if (stb.clrPend) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/prescaled_tick_timer.sv
module prescaled_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W = 4,
  parameter int MIN_RELOAD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refStrobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              tickIrq
);
  tickStb_t ctrlStb;
  logic ctrlEn;
  logic ctrlTickEn;
  logic [SEL_W-1:0] ctrlSel;
  logic running;
  logic [DATA_W-1:0] reloadVal;
  logic [DATA_W-1:0] liveCnt;
  logic pending;
  logic [DATA_W-1:0] ctrlWord;

  tick_timer_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MIN_RELOAD(MIN_RELOAD)) i_ctrl (
    .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .reloadNonzero(reloadVal != '0), .stb(ctrlStb), .ctrlEn(ctrlEn),
    .ctrlTickEn(ctrlTickEn), .ctrlSel(ctrlSel), .running(running)
  );

  tick_timer_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .wrData(wrData),
    .reloadVal(reloadVal), .liveCnt(liveCnt), .pending(pending)
  );

  always_comb begin
    ctrlWord = '0;
    ctrlWord[EN_BIT] = ctrlEn;
    ctrlWord[TICK_BIT] = ctrlTickEn;
    ctrlWord[SEL_LSB +: SEL_W] = ctrlSel;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL:   rdData = ctrlWord;
      ADDR_RELOAD: rdData = reloadVal;
      ADDR_PEND:   rdData = {{(DATA_W-1){1'b0}}, pending};
      default:     rdData = liveCnt;
    endcase
  end

  assign tickIrq = pending;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              tickIrq,
  input logic [DATA_W-1:0] liveCnt,
  input logic [DATA_W-1:0] reloadVal,
  input logic              running,
  input logic              step,
  input logic              load
);
  logic clrWr;
  assign clrWr = wrEn && (wrAddr == 2'd2) && wrData[0];

  // R5: the interrupt holds until a clear write
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq && !clrWr |=> tickIrq);

  // R5: a step at count 1 raises the interrupt and reloads
  a_r5_expire_sets: assert property (@(posedge clk) disable iff (!rstN)
    step && !load && (liveCnt <= 1) |=> tickIrq && (liveCnt == $past(reloadVal)));

  // R6: a clear with no simultaneous expiry drops the line
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    clrWr && !(step && (liveCnt <= 1)) |=> !tickIrq);

  // R4: stopped and not starting means a frozen count
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !running && !load |=> $stable(liveCnt));

  // R7: a step above 1 decrements by exactly one
  a_r7_decrement: assert property (@(posedge clk) disable iff (!rstN)
    step && !load && (liveCnt > 1) |=> liveCnt == $past(liveCnt) - 1);

  // R2: small reload writes leave the register unchanged
  a_r2_reject_small: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrAddr == 2'd1) && (wrData <= 2) |=> $stable(reloadVal));
endmodule

bind prescaled_tick_timer tick_timer_checker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .tickIrq(tickIrq), .liveCnt(liveCnt), .reloadVal(reloadVal), .running(running),
  .step(ctrlStb.step), .load(ctrlStb.load)
);

// File: tb/test_prescaled_tick_timer.sv
module test_prescaled_tick_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refStrobe = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [15:0] rdData;
  logic tickIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prescaled_tick_timer i_prescaled_tick_timer (
    .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .tickIrq(tickIrq)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(logic [1:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refStrobe = 1'b1;
      @(negedge clk); refStrobe = 1'b0;
    end
  endtask

  task automatic checkLive(string req, int exp);
    int v;
    readReg(2'd3, v);
    checkVal(req, "live count", v, exp);
  endtask

  task automatic checkIrq(string req, int exp);
    checkVal(req, "tick irq", int'(tickIrq), exp);
  endtask

  task automatic testReset();
    int v;
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), v);
      checkVal("R8", "register after reset", v, 0);
    end
    checkIrq("R8", 0);
  endtask

  task automatic testZeroReload();
    writeReg(2'd0, 16'h0101);
    pulses(10);
    checkLive("R3", 0);
    checkIrq("R3", 0);
    writeReg(2'd0, 16'h0001);
  endtask

  task automatic testReject();
    int v;
    writeReg(2'd1, 16'd2); readReg(2'd1, v); checkVal("R2", "reload after 2", v, 0);
    writeReg(2'd1, 16'd5); readReg(2'd1, v); checkVal("R2", "reload after 5", v, 5);
    writeReg(2'd1, 16'd1); readReg(2'd1, v); checkVal("R2", "reload after 1", v, 5);
    writeReg(2'd1, 16'd0); readReg(2'd1, v); checkVal("R2", "reload after 0", v, 5);
  endtask

  task automatic testStartExpire();
    int v;
    writeReg(2'd0, 16'h0101);
    checkLive("R3", 5);
    pulses(2); checkLive("R7", 3);
    pulses(2); checkLive("R7", 1); checkIrq("R5", 0);
    pulses(1); checkIrq("R5", 1); checkLive("R5", 5);
    readReg(2'd2, v); checkVal("R5", "pending bit", v, 1);
  endtask

  task automatic testClear();
    int v;
    writeReg(2'd2, 16'h0000); checkIrq("R6", 1);
    writeReg(2'd2, 16'h0001); checkIrq("R6", 0);
    readReg(2'd2, v); checkVal("R6", "pending after clear", v, 0);
    pulses(4); checkIrq("R5", 0);
    pulses(1); checkIrq("R5", 1);
    writeReg(2'd2, 16'h0001);
  endtask

  task automatic testNoRestart();
    pulses(2); checkLive("R7", 3);
    writeReg(2'd0, 16'h0101); checkLive("R3", 3);
  endtask

  task automatic testStop();
    writeReg(2'd0, 16'h0001);
    pulses(8); checkLive("R4", 3); checkIrq("R4", 0);
    writeReg(2'd0, 16'h0101); checkLive("R3", 5);
    writeReg(2'd0, 16'h0000);
    pulses(8); checkLive("R4", 5); checkIrq("R4", 0);
    writeReg(2'd0, 16'h0100);
    pulses(3); checkLive("R3", 5);
    writeReg(2'd0, 16'h0001);
  endtask

  task automatic testPrescale();
    int v;
    writeReg(2'd1, 16'd3);
    writeReg(2'd0, 16'h0121);
    readReg(2'd0, v); checkVal("R1", "control readback", v, 16'h0121);
    checkLive("R3", 3);
    pulses(3); checkLive("R1", 3);
    pulses(1); checkLive("R1", 2);
    pulses(4); checkLive("R1", 1);
    pulses(3); checkIrq("R1", 0);
    pulses(1); checkIrq("R1", 1); checkLive("R1", 3);
    writeReg(2'd2, 16'h0001);
    writeReg(2'd0, 16'h0021);
  endtask

  task automatic testSetWins();
    writeReg(2'd0, 16'h0101);
    checkLive("R3", 3);
    pulses(2); checkLive("R7", 1); checkIrq("R6", 0);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 16'h0001; refStrobe = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; refStrobe = 1'b0;
    checkIrq("R6", 1);
    checkLive("R5", 3);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroReload();
    testReject();
    testStartExpire();
    testClear();
    testNoRestart();
    testStop();
    testPrescale();
    testSetWins();
    finishRun();
  end
endmodule